// File: doc/BRIEF.md
# Reconfigurable Dynamic-Programming Systolic Cell

This block is one processing element of a linear systolic array that fills a dynamic-programming score table one anti-diagonal per clock. The cell keeps a single reference symbol and the score it produced last. Each valid cycle it compares that reference with the symbol streaming past. From the comparison and three neighbour scores it forms one new table entry: the left score from the neighbour's fresh result, the diagonal score from the neighbour's older result, and the up score from its own last result. A two-bit mode input picks the recurrence. The choices are local alignment, global alignment, longest common subsequence, or approximate (edit-distance) string matching.

Besides the score, the cell emits a three-bit origin pointer. A host can use it to trace back the winning path. The cell forwards the streamed symbol, a valid flag, its new score and its previous score to the next cell to the right. Before a run, a load strobe writes the reference symbol and the boundary value for the cell's table row.

Top module: `dp_cell`

## Requirements
- R1: Symbols are 2-bit codes (A=00, T=01, C=10, G=11). A match is when the streamed symbol code equals the stored reference code.
- R2: Mode 00 (local alignment): new score = max(left-2, up-2, diag+p, 0), where p=+1 on a match and -1 on a mismatch.
- R3: Mode 01 (global alignment): new score = max(left-2, up-2, diag+p) with the same p as R2, and no zero floor, so results may be negative.
- R4: Mode 10 (longest common subsequence): new score = max(left, up, diag+p), where p=1 on a match and 0 otherwise.
- R5: Mode 11 (approximate matching): new score = min(left+1, up+1, diag+p), where p=0 on a match and 1 otherwise.
- R6: out_ptr_o bit 2 marks diagonal, bit 1 marks up and bit 0 marks left. Every candidate equal to the chosen value sets its bit. The code 000 appears only in mode 00, when all three candidates are below zero and the score restarts at 0.
- R7: A valid sample updates the cell on the next clock edge. out_score_o becomes the new score and out_diag_o takes the previous out_score_o. out_sym_o takes the streamed symbol, out_valid_o is 1 and out_ptr_o is the new pointer.
- R8: While in_valid_i and ref_load_i are both low, out_score_o, out_diag_o, out_ptr_o and out_sym_o hold, and out_valid_o is 0 one cycle later.
- R9: Scores are signed two's complement of SCORE_W bits (default 10, range -512..511). A result outside that range saturates to the nearest limit.
- R10: ref_load_i writes ref_sym_i as the reference and init_score_i as the up value. It takes priority over a simultaneous valid sample, which is dropped (out_valid_o is 0 the next cycle).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 2 | Recurrence select: 00 local, 01 global, 10 LCS, 11 approximate |
| ref_load_i | input | 1 | Load reference symbol and row boundary score |
| ref_sym_i | input | SYM_W | Reference symbol to load |
| init_score_i | input | SCORE_W | Boundary score loaded as the up value |
| in_valid_i | input | 1 | Streamed sample is valid |
| in_sym_i | input | SYM_W | Streamed symbol |
| in_left_i | input | SCORE_W | Left neighbour's newest score (signed) |
| in_diag_i | input | SCORE_W | Left neighbour's previous score (signed) |
| out_valid_o | output | 1 | Forwarded valid flag |
| out_sym_o | output | SYM_W | Forwarded symbol |
| out_score_o | output | SCORE_W | Newest score of this cell (signed) |
| out_diag_o | output | SCORE_W | Previous score of this cell (signed) |
| out_ptr_o | output | 3 | Origin pointer of the newest score |

## Verification
The bench aims at ties among candidates. A selector that stops at the first winner would report one pointer bit where two or three are owed. It also covers local-mode cases where every candidate is negative: a design that forgot the floor, or that flagged restarts with a nonzero code, shows a wrong score or pointer there. Saturation is driven at both ends of the score range, so a design that wraps instead of clamping returns a value of the opposite sign. Idle cycles and loads that collide with a valid sample expose a cell that shifts its diagonal or raises out_valid_o when it should hold.

// File: rtl/dp_cell_pkg.sv
`timescale 1ns/1ps
package dp_cell_pkg;

    typedef enum logic [1:0] {
        MODE_LOCAL  = 2'b00,
        MODE_GLOBAL = 2'b01,
        MODE_LCS    = 2'b10,
        MODE_EDIT   = 2'b11
    } dp_mode_e;

    localparam int NUM_CAND = 3;

    localparam int CAND_LEFT = 0;
    localparam int CAND_UP   = 1;
    localparam int CAND_DIAG = 2;

endpackage

// File: rtl/dp_cand_gen.sv
`timescale 1ns/1ps
module dp_cand_gen
    import dp_cell_pkg::*;
#(
    parameter  int SCORE_W = 10,
    parameter  int SYM_W   = 2,
    localparam int WIDE_W  = SCORE_W + 2
) (
    input  dp_mode_e                             mode_i,
    input  logic [SYM_W-1:0]                     sym_i,
    input  logic [SYM_W-1:0]                     ref_i,
    input  logic signed [SCORE_W-1:0]            left_i,
    input  logic signed [SCORE_W-1:0]            up_i,
    input  logic signed [SCORE_W-1:0]            diag_i,
    output logic [NUM_CAND-1:0][WIDE_W-1:0]      cand_o
);

    logic                     hit;
    logic signed [WIDE_W-1:0] gap;
    logic signed [WIDE_W-1:0] bonus;
    logic signed [WIDE_W-1:0] left_w;
    logic signed [WIDE_W-1:0] up_w;
    logic signed [WIDE_W-1:0] diag_w;

    always_comb begin
        hit    = (sym_i == ref_i);
        left_w = WIDE_W'(left_i);
        up_w   = WIDE_W'(up_i);
        diag_w = WIDE_W'(diag_i);
        case (mode_i)
            MODE_LOCAL, MODE_GLOBAL: begin
                gap   = -WIDE_W'(2);
                bonus = hit ? WIDE_W'(1) : -WIDE_W'(1);
            end
            MODE_LCS: begin
                gap   = '0;
                bonus = hit ? WIDE_W'(1) : '0;
            end
            default: begin
                gap   = WIDE_W'(1);
                bonus = hit ? '0 : WIDE_W'(1);
            end
        endcase
        cand_o[CAND_LEFT] = left_w + gap;
        cand_o[CAND_UP]   = up_w + gap;
        cand_o[CAND_DIAG] = diag_w + bonus;
    end

endmodule

// File: rtl/dp_select.sv
`timescale 1ns/1ps
module dp_select
    import dp_cell_pkg::*;
#(
    parameter  int SCORE_W = 10,
    localparam int WIDE_W  = SCORE_W + 2
) (
    input  dp_mode_e                         mode_i,
    input  logic [NUM_CAND-1:0][WIDE_W-1:0]  cand_i,
    output logic signed [SCORE_W-1:0]        score_o,
    output logic [NUM_CAND-1:0]              ptr_o
);

    localparam logic signed [WIDE_W-1:0] SAT_HI = {3'b000, {(SCORE_W-1){1'b1}}};
    localparam logic signed [WIDE_W-1:0] SAT_LO = {3'b111, {(SCORE_W-1){1'b0}}};

    logic                     take_min;
    logic signed [WIDE_W-1:0] best;
    logic signed [WIDE_W-1:0] floored;
    logic [NUM_CAND-1:0]      tie;

    always_comb begin
        take_min = (mode_i == MODE_EDIT);
        best     = $signed(cand_i[0]);
        for (int k = 1; k < NUM_CAND; k++) begin
            if (take_min ? ($signed(cand_i[k]) < best) : ($signed(cand_i[k]) > best)) begin
                best = $signed(cand_i[k]);
            end
        end
    end

    for (genvar g = 0; g < NUM_CAND; g++) begin : g_tie
        assign tie[g] = ($signed(cand_i[g]) == best);
    end

    always_comb begin
        if (mode_i == MODE_LOCAL && best < 0) begin
            floored = '0;
            ptr_o   = '0;
        end else begin
            floored = best;
            ptr_o   = tie;
        end
        if (floored > SAT_HI) begin
            score_o = SAT_HI[SCORE_W-1:0];
        end else if (floored < SAT_LO) begin
            score_o = SAT_LO[SCORE_W-1:0];
        end else begin
            score_o = floored[SCORE_W-1:0];
        end
    end

endmodule

// File: rtl/dp_cell.sv
`timescale 1ns/1ps
module dp_cell
    import dp_cell_pkg::*;
#(
    parameter  int SCORE_W = 10,
    parameter  int SYM_W   = 2,
    localparam int WIDE_W  = SCORE_W + 2
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                mode_i,
    input  logic                      ref_load_i,
    input  logic [SYM_W-1:0]          ref_sym_i,
    input  logic signed [SCORE_W-1:0] init_score_i,
    input  logic                      in_valid_i,
    input  logic [SYM_W-1:0]          in_sym_i,
    input  logic signed [SCORE_W-1:0] in_left_i,
    input  logic signed [SCORE_W-1:0] in_diag_i,
    output logic                      out_valid_o,
    output logic [SYM_W-1:0]          out_sym_o,
    output logic signed [SCORE_W-1:0] out_score_o,
    output logic signed [SCORE_W-1:0] out_diag_o,
    output logic [2:0]                out_ptr_o
);

    typedef struct packed {
        logic [SYM_W-1:0]          ref_sym;
        logic signed [SCORE_W-1:0] up;
        logic signed [SCORE_W-1:0] diag;
        logic [NUM_CAND-1:0]       ptr;
        logic [SYM_W-1:0]          sym;
        logic                      valid;
    } cell_st_t;

    cell_st_t st_d, st_q;

    dp_mode_e                        mode;
    logic [NUM_CAND-1:0][WIDE_W-1:0] cand;
    logic signed [SCORE_W-1:0]       new_score;
    logic [NUM_CAND-1:0]             new_ptr;

    assign mode = dp_mode_e'(mode_i);

    dp_cand_gen #(
        .SCORE_W (SCORE_W),
        .SYM_W   (SYM_W)
    ) u_cand (
        .mode_i  (mode),
        .sym_i   (in_sym_i),
        .ref_i   (st_q.ref_sym),
        .left_i  (in_left_i),
        .up_i    (st_q.up),
        .diag_i  (in_diag_i),
        .cand_o  (cand)
    );

    dp_select #(
        .SCORE_W (SCORE_W)
    ) u_sel (
        .mode_i  (mode),
        .cand_i  (cand),
        .score_o (new_score),
        .ptr_o   (new_ptr)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = 1'b0;
        if (ref_load_i) begin
            st_d.ref_sym = ref_sym_i;
            st_d.up      = init_score_i;
        end else if (in_valid_i) begin
            st_d.diag  = st_q.up;
            st_d.up    = new_score;
            st_d.ptr   = new_ptr;
            st_d.sym   = in_sym_i;
            st_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid_o = st_q.valid;
    assign out_sym_o   = st_q.sym;
    assign out_score_o = st_q.up;
    assign out_diag_o  = st_q.diag;
    assign out_ptr_o   = st_q.ptr;

endmodule

// File: rtl/dp_cell_chk.sv
`timescale 1ns/1ps
module dp_cell_chk #(
    parameter int SCORE_W = 10,
    parameter int SYM_W   = 2
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic [1:0]                mode_i,
    input logic                      ref_load_i,
    input logic                      in_valid_i,
    input logic [SYM_W-1:0]          in_sym_i,
    input logic                      out_valid_o,
    input logic [SYM_W-1:0]          out_sym_o,
    input logic signed [SCORE_W-1:0] out_score_o,
    input logic signed [SCORE_W-1:0] out_diag_o,
    input logic [2:0]                out_ptr_o
);

    logic take;
    assign take = in_valid_i && !ref_load_i;

    AST_LOCAL_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode_i == 2'b00 |=> out_score_o >= 0); // R2

    AST_LCS_NO_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode_i == 2'b10 |=> out_score_o >= $past(out_score_o)); // R4

    AST_EDIT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode_i == 2'b11 |=> int'(out_score_o) <= int'($past(out_score_o)) + 1); // R5

    AST_RESTART_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o && out_ptr_o == 3'b000 |-> out_score_o == '0); // R6

    AST_PTR_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        take && mode_i != 2'b00 |=> out_ptr_o != 3'b000); // R6

    AST_DIAG_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_diag_o == $past(out_score_o)); // R7

    AST_SYM_FWD: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> out_valid_o && out_sym_o == $past(in_sym_i)); // R7

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid_i && !ref_load_i |=> !out_valid_o && $stable(out_score_o)
            && $stable(out_diag_o) && $stable(out_ptr_o) && $stable(out_sym_o)); // R8

    AST_LOAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        ref_load_i |=> !out_valid_o && $stable(out_diag_o)); // R10

endmodule

bind dp_cell dp_cell_chk #(
    .SCORE_W (SCORE_W),
    .SYM_W   (SYM_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .ref_load_i  (ref_load_i),
    .in_valid_i  (in_valid_i),
    .in_sym_i    (in_sym_i),
    .out_valid_o (out_valid_o),
    .out_sym_o   (out_sym_o),
    .out_score_o (out_score_o),
    .out_diag_o  (out_diag_o),
    .out_ptr_o   (out_ptr_o)
);

// File: tb/dp_cell_tb.sv
`timescale 1ns/1ps
module dp_cell_tb;

    localparam int W    = 10;
    localparam int SW   = 2;
    localparam int SMAX = 511;
    localparam int SMIN = -512;

    logic                clk = 1'b0;
    logic                rst_n;
    logic [1:0]          mode;
    logic                ref_load;
    logic [SW-1:0]       ref_sym;
    logic signed [W-1:0] init_score;
    logic                in_valid;
    logic [SW-1:0]       in_sym;
    logic signed [W-1:0] in_left;
    logic signed [W-1:0] in_diag;
    logic                out_valid;
    logic [SW-1:0]       out_sym;
    logic signed [W-1:0] out_score;
    logic signed [W-1:0] out_diag;
    logic [2:0]          out_ptr;

    always #2.5 clk = ~clk;

    dp_cell #(.SCORE_W(W), .SYM_W(SW)) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i       (mode),
        .ref_load_i   (ref_load),
        .ref_sym_i    (ref_sym),
        .init_score_i (init_score),
        .in_valid_i   (in_valid),
        .in_sym_i     (in_sym),
        .in_left_i    (in_left),
        .in_diag_i    (in_diag),
        .out_valid_o  (out_valid),
        .out_sym_o    (out_sym),
        .out_score_o  (out_score),
        .out_diag_o   (out_diag),
        .out_ptr_o    (out_ptr)
    );

    int n_chk = 0;
    int n_err = 0;
    int m_up = 0, m_diag = 0, m_ptr = 0, m_sym = 0, m_valid = 0, m_ref = 0;
    bit done = 0;

    task automatic chk(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Behavioural recurrence evaluation on plain integers.
    task automatic ref_eval(input int md, input int lft, input int up, input int dg,
                            input bit match, output int res, output int ptr, output bit sat);
        int c[3];
        int best;
        case (md)
            0, 1: begin c[0] = lft - 2; c[1] = up - 2; c[2] = dg + (match ? 1 : -1); end
            2:    begin c[0] = lft;     c[1] = up;     c[2] = dg + (match ? 1 : 0);  end
            default: begin c[0] = lft + 1; c[1] = up + 1; c[2] = dg + (match ? 0 : 1); end
        endcase
        best = c[0];
        if (md == 3) begin
            if (c[1] < best) best = c[1];
            if (c[2] < best) best = c[2];
        end else begin
            if (c[1] > best) best = c[1];
            if (c[2] > best) best = c[2];
        end
        ptr = 0;
        if (c[0] == best) ptr += 1;
        if (c[1] == best) ptr += 2;
        if (c[2] == best) ptr += 4;
        res = best;
        if (md == 0 && best < 0) begin res = 0; ptr = 0; end
        sat = 0;
        if (res > SMAX) begin res = SMAX; sat = 1; end
        if (res < SMIN) begin res = SMIN; sat = 1; end
    endtask

    task automatic step(bit ld, int rsym, int init, bit vld, int md, int sym,
                        int lft, int dg, string tag);
        int res, ptr;
        bit sat;
        string ts, tp, tf;
        @(negedge clk);
        ref_load   = ld;
        ref_sym    = SW'(rsym);
        init_score = W'(init);
        in_valid   = vld;
        mode       = 2'(md);
        in_sym     = SW'(sym);
        in_left    = W'(lft);
        in_diag    = W'(dg);
        ts = tag; tp = tag; tf = tag;
        if (ld) begin
            m_ref = rsym; m_up = init; m_valid = 0;
            if (tag == "") begin ts = "R10"; tp = "R10"; tf = "R10"; end
        end else if (vld) begin
            ref_eval(md, lft, m_up, dg, (sym == m_ref), res, ptr, sat);
            m_diag = m_up; m_up = res; m_ptr = ptr; m_sym = sym; m_valid = 1;
            if (tag == "") begin
                case (md)
                    0: ts = "R2";
                    1: ts = "R3";
                    2: ts = "R4";
                    default: ts = "R5";
                endcase
                if (sat) ts = "R9";
                tp = "R6"; tf = "R7";
            end
        end else begin
            m_valid = 0;
            if (tag == "") begin ts = "R8"; tp = "R8"; tf = "R8"; end
        end
        @(posedge clk);
        #1;
        chk(ts, "score", int'(out_score), m_up);
        chk(tp, "ptr",   int'(out_ptr),   m_ptr);
        chk(tf, "diag",  int'(out_diag),  m_diag);
        chk(tf, "sym",   int'(out_sym),   m_sym);
        chk(tf, "valid", int'(out_valid), m_valid);
    endtask

    initial begin
        for (int c = 0; c < 200000; c++) @(posedge clk);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired before the test sequence ended");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; mode = '0; ref_load = 0; ref_sym = '0; init_score = '0;
        in_valid = 0; in_sym = '0; in_left = '0; in_diag = '0;
        repeat (4) @(posedge clk);
        #1;
        chk("R7", "reset score", int'(out_score), 0);
        chk("R7", "reset valid", int'(out_valid), 0);
        chk("R6", "reset ptr",   int'(out_ptr),   0);
        @(negedge clk);
        rst_n = 1'b1;

        // R10 load reference A (00), boundary 0; then R2 local match
        step(1, 0, 0, 0, 0, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 0, 0, 0, 0, "R2");        // 1, ptr 100
        step(0, 0, 0, 1, 0, 1, 0, 0, "R6");        // all negative -> restart 0, ptr 000
        step(0, 0, 0, 1, 0, 0, 3, 0, "R6");        // up-2 vs left-2 vs diag+1 -> ties
        step(0, 0, 0, 1, 0, 0, 4, 1, "R6");        // left 2, diag 2 tie
        // R3 global negative scores
        step(1, 0, -4, 0, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 1, 2, -6, -3, "R3");      // -4 ptr 100
        step(0, 0, 0, 1, 1, 2, -9, -9, "R3");      // -6 from up
        // R4 LCS three-way tie
        step(1, 0, 3, 0, 2, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 2, 0, 3, 2, "R4");        // 3, ptr 111
        step(0, 0, 0, 1, 2, 3, 1, 5, "R4");        // mismatch: diag 5
        // R5 approximate matching
        step(1, 0, 2, 0, 3, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 3, 3, 1, 1, "R5");        // 2, ptr 101
        step(0, 0, 0, 1, 3, 0, 7, 0, "R5");        // match: diag 0
        // R8 idle cycles hold
        step(0, 0, 0, 0, 0, 1, 100, 100, "R8");
        step(0, 0, 0, 0, 2, 2, -50, 9, "R8");
        // R10 load collides with valid: sample dropped
        step(1, 2, 5, 1, 2, 2, 9, 9, "R10");
        // R1 symbol code sweep against reference C (10)
        for (int s = 0; s < 4; s++) begin
            step(1, 2, 0, 0, 2, 0, 0, 0, "R10");
            step(0, 0, 0, 1, 2, s, 0, 0, "R1");    // 1 only when code is 10
        end
        // R9 saturation at both ends
        step(1, 0, SMAX, 0, 2, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 2, 0, SMAX, SMAX, "R9");
        step(1, 0, SMIN, 0, 1, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 1, 1, SMIN, SMIN, "R9");
        step(1, 0, SMAX, 0, 3, 0, 0, 0, "R10");
        step(0, 0, 0, 1, 3, 1, SMAX, SMAX, "R9");

        // Mixed random traffic
        for (int i = 0; i < 3000; i++) begin
            int r = $urandom_range(0, 19);
            if (r == 0)
                step(1, $urandom_range(0, 3), $urandom_range(0, 600) - 300, 0,
                     0, 0, 0, 0, "");
            else
                step(0, 0, 0, (r > 3), $urandom_range(0, 3), $urandom_range(0, 3),
                     $urandom_range(0, 1023) - 512, $urandom_range(0, 1023) - 512, "");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule